// File: doc/BRIEF.md
# 64 KiB Granule Translation Table Walker

This block turns a virtual address into a physical address by walking a translation table held in memory. It handles one translation stage with a single address range, a 64 KiB granule and a 48-bit input space. For each level it reads one 64-bit descriptor through a simple memory read port, with one request and one response. The walk can take up to three reads. It can stop early when it finds a block descriptor at level 1 or level 2, and it always stops at level 3.

The requester checks that `ready_o` is high, then pulses `start_i` together with the virtual address and the root table base. When the walk ends, the block raises `done_o` for exactly one cycle. With that pulse it gives either the physical address and the attribute fields of the final descriptor, or a fault together with the level at which the walk stopped. Only one walk is in progress at a time.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `ready_o` is 1 and both `done_o` and `mem_req_o` are 0.
- R2: The first read goes to `root_base_i + VA[47:42]*8`. It is issued as a one-cycle `mem_req_o` pulse in the cycle after `start_i` is accepted.
- R3: A descriptor whose bits [1:0] are 0b11, found at level 1 or level 2, is a table pointer. The next read goes to `{desc[47:16], 16'h0} + idx*8`, where idx is VA[41:29] for level 2 and VA[28:16] for level 3. The access flag of a table pointer is not checked.
- R4: A level-1 block (bits [1:0] = 0b01) ends the walk with PA = {desc[47:42], VA[41:0]}.
- R5: A level-2 block ends the walk with PA = {desc[47:29], VA[28:0]}.
- R6: A level-3 entry with bits [1:0] = 0b11 is a page, and PA = {desc[47:16], VA[15:0]}.
- R7: On success, `attr_idx_o` = desc[4:2], `perm_o` = desc[7:6] and `share_o` = desc[9:8], all taken from the final descriptor.
- R8: A descriptor with bit 0 clear faults at its level. On any fault, `pa_o`, `attr_idx_o`, `perm_o` and `share_o` are 0.
- R9: A final block or page descriptor with bit 10 (the access flag) clear faults at its level.
- R10: At level 3 the encoding 0b01 faults with level 3.
- R11: If any of VA[63:48] is set, the block faults with level 0 and issues no memory read.
- R12: Each walk issues exactly one read per level it visits and exactly one `done_o` pulse. `ready_o` returns to 1 in the cycle after `done_o`. A `start_i` that arrives while a walk is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a walk when `ready_o` is 1 |
| va_i | input | 64 | Virtual address to translate |
| root_base_i | input | 48 | Root table base, 512-byte aligned |
| ready_o | output | 1 | Block is idle and can accept a start |
| mem_req_o | output | 1 | Descriptor read request, one-cycle pulse |
| mem_addr_o | output | 48 | Byte address of the descriptor |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Descriptor returned by the read |
| done_o | output | 1 | Walk complete, one-cycle pulse |
| fault_o | output | 1 | The walk ended in a fault |
| fault_level_o | output | 2 | Level where the walk stopped (0 for an out-of-range address) |
| pa_o | output | 48 | Translated physical address |
| attr_idx_o | output | 3 | Memory attribute index |
| share_o | output | 2 | Shareability field |
| perm_o | output | 2 | Access permission field |

## Verification
Two cases are the hardest to reach from the ports. The first is a start that arrives while a read is still outstanding. The second is a three-level walk whose index fields are all at their maximum. The bench's memory responder returns each descriptor several cycles after the request. It checks every fetch address against the address built from the virtual address and the previous descriptor. In one pass it pulses `start_i` with a different address during the wait, and then checks that the request count and the result are unchanged. Descriptors are chosen to carry non-zero bits below the block boundary, and a table pointer is given a clear access flag. Together these show that the address splicing and the access-flag check each apply only where they belong.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned OA_W      = 48;
  localparam int unsigned VA_W      = 64;
  localparam int unsigned DESC_W    = 64;
  localparam int unsigned GRAN_SH   = 16;
  localparam int unsigned TBL_IDX_W = 13;
  localparam int unsigned NUM_LVL   = 3;
  localparam int unsigned ENTRY_SH  = 3;
  // bit where each level's index starts
  localparam int unsigned SH_L3     = GRAN_SH;
  localparam int unsigned SH_L2     = GRAN_SH + TBL_IDX_W;
  localparam int unsigned SH_L1     = GRAN_SH + 2 * TBL_IDX_W;
  localparam int unsigned ROOT_IDX_W = OA_W - SH_L1;
  // descriptor field positions
  localparam int unsigned AF_BIT    = 10;
  localparam int unsigned SHR_LO    = 8;
  localparam int unsigned AP_LO     = 6;
  localparam int unsigned ATTR_LO   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} walk_st_e;

  typedef struct packed {
    logic [OA_W-1:0] pa;
    logic [2:0]      attr;
    logic [1:0]      share;
    logic [1:0]      perm;
  } xlat_res_t;
endpackage

// File: rtl/xlat_index.sv
module xlat_index
  import xlat_pkg::*;
(
  input  logic [1:0]      lvl_i,
  input  logic [OA_W-1:0] va_i,
  input  logic [OA_W-1:0] base_i,
  output logic [OA_W-1:0] addr_o
);
  logic [TBL_IDX_W-1:0] idx;

  always_comb begin
    case (lvl_i)
      2'd1:    idx = TBL_IDX_W'(va_i[SH_L1 +: ROOT_IDX_W]);
      2'd2:    idx = va_i[SH_L2 +: TBL_IDX_W];
      default: idx = va_i[SH_L3 +: TBL_IDX_W];
    endcase
  end

  assign addr_o = base_i + (OA_W'(idx) << ENTRY_SH);

  logic unused_va;
  assign unused_va = ^va_i[SH_L3-1:0];
endmodule

// File: rtl/xlat_dec.sv
module xlat_dec
  import xlat_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  input  logic [1:0]        lvl_i,
  input  logic [OA_W-1:0]   va_i,
  output logic              next_o,
  output logic              fault_o,
  output logic [OA_W-1:0]   next_base_o,
  output xlat_res_t         res_o
);
  localparam logic [1:0] LAST_LVL = 2'(NUM_LVL);

  logic [1:0]      ty;
  logic            term_ok;
  logic [5:0]      sh;
  logic [OA_W-1:0] hi_mask;

  assign ty      = desc_i[1:0];
  assign next_o  = (ty == 2'b11) && (lvl_i != LAST_LVL);
  // last level takes only the page encoding, earlier levels only block
  assign term_ok = (lvl_i == LAST_LVL) ? (ty == 2'b11) : (ty == 2'b01);
  assign fault_o = !desc_i[0] || (!next_o && (!term_ok || !desc_i[AF_BIT]));

  always_comb begin
    case (lvl_i)
      2'd1:    sh = 6'(SH_L1);
      2'd2:    sh = 6'(SH_L2);
      default: sh = 6'(SH_L3);
    endcase
  end

  assign hi_mask     = {OA_W{1'b1}} << sh;
  assign next_base_o = {desc_i[OA_W-1:GRAN_SH], {GRAN_SH{1'b0}}};

  always_comb begin
    res_o.pa    = (desc_i[OA_W-1:0] & hi_mask) | (va_i & ~hi_mask);
    res_o.attr  = desc_i[ATTR_LO +: 3];
    res_o.perm  = desc_i[AP_LO +: 2];
    res_o.share = desc_i[SHR_LO +: 2];
  end

  logic unused_desc;
  assign unused_desc = ^{desc_i[DESC_W-1:OA_W], desc_i[5]};
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [OA_W-1:0]   root_base_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic [OA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_level_o,
  output logic [OA_W-1:0]   pa_o,
  output logic [2:0]        attr_idx_o,
  output logic [1:0]        share_o,
  output logic [1:0]        perm_o
);
  walk_st_e        st_q;
  logic [OA_W-1:0] va_q, base_q, next_base;
  logic [1:0]      lvl_q, flvl_q;
  logic            fault_q, dec_next, dec_fault, out_range;
  xlat_res_t       res_q, dec_res;

  assign out_range = |va_i[VA_W-1:OA_W];

  xlat_index u_index (
    .lvl_i (lvl_q),
    .va_i  (va_q),
    .base_i(base_q),
    .addr_o(mem_addr_o)
  );

  xlat_dec u_dec (
    .desc_i     (mem_rdata_i),
    .lvl_i      (lvl_q),
    .va_i       (va_q),
    .next_o     (dec_next),
    .fault_o    (dec_fault),
    .next_base_o(next_base),
    .res_o      (dec_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      lvl_q   <= 2'd1;
      flvl_q  <= 2'd0;
      fault_q <= 1'b0;
      res_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          va_q   <= va_i[OA_W-1:0];
          base_q <= root_base_i;
          lvl_q  <= 2'd1;
          res_q  <= '0;
          if (out_range) begin
            fault_q <= 1'b1;
            flvl_q  <= 2'd0;
            st_q    <= ST_DONE;
          end else begin
            fault_q <= 1'b0;
            flvl_q  <= 2'd0;
            st_q    <= ST_REQ;
          end
        end
        ST_REQ: st_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          if (dec_next) begin
            base_q <= next_base;
            lvl_q  <= lvl_q + 2'd1;
            st_q   <= ST_REQ;
          end else begin
            st_q <= ST_DONE;
            if (dec_fault) begin
              fault_q <= 1'b1;
              flvl_q  <= lvl_q;
              res_q   <= '0;
            end else begin
              res_q <= dec_res;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o       = (st_q == ST_IDLE);
  assign mem_req_o     = (st_q == ST_REQ);
  assign done_o        = (st_q == ST_DONE);
  assign fault_o       = fault_q;
  assign fault_level_o = flvl_q;
  assign pa_o          = res_q.pa;
  assign attr_idx_o    = res_q.attr;
  assign share_o       = res_q.share;
  assign perm_o        = res_q.perm;

  // R2
  root_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && !out_range) |=> (mem_req_o &&
      mem_addr_o == $past(root_base_i) + (OA_W'($past(va_i[SH_L1 +: ROOT_IDX_W])) << ENTRY_SH)));

  // R11
  range_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && out_range) |=> (done_o && fault_o && fault_level_o == 2'd0 && !mem_req_o));

  // R12
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o && !done_o);

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (ready_o && !done_o));

  // R8
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (pa_o == '0 && attr_idx_o == 3'd0 && perm_o == 2'd0 && share_o == 2'd0));

  // R12
  no_req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);
endmodule

// File: tb/tb_xlat_walker.sv
module tb_xlat_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] va_i = '0;
  logic [47:0] root_base_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        ready_o, mem_req_o, done_o, fault_o;
  logic [47:0] mem_addr_o, pa_o;
  logic [1:0]  fault_level_o, share_o, perm_o;
  logic [2:0]  attr_idx_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  xlat_walker dut (.*);

  function automatic logic [63:0] mk(input logic [47:0] a, input logic [1:0] ty, input logic af,
                                     input logic [2:0] attr, input logic [1:0] ap, input logic [1:0] sh);
    return {16'h0, a[47:16], 5'b0, af, sh, ap, 1'b0, attr, ty};
  endfunction

  typedef struct packed {
    logic [63:0] va;
    logic [47:0] root;
    logic [63:0] d1, d2, d3;
    logic        flt;
    logic [1:0]  lvl;
  } vec_t;

  localparam logic [47:0] ROOT = 48'h0000_0040_0200;
  localparam vec_t VECS [12] = '{
    // R4 level-1 block with junk below bit 42
    '{64'h0000_1234_5678_9ABC, ROOT, mk(48'hAC00_1234_0000, 2'b01, 1, 3'd3, 2'd1, 2'd3), 64'h0, 64'h0, 1'b0, 2'd1},
    // R5 level-2 block
    '{64'h0000_0BAD_CAFE_1234, ROOT, mk(48'h0000_0123_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0),
      mk(48'h0000_E123_0000, 2'b01, 1, 3'd5, 2'd2, 2'd2), 64'h0, 1'b0, 2'd2},
    // R6 level-3 page, all index bits set
    '{64'h0000_FFFF_FFFF_FFFF, ROOT, mk(48'h0000_0010_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0),
      mk(48'h0000_0020_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0), mk(48'h7FFF_FFFF_0000, 2'b11, 1, 3'd7, 2'd3, 2'd1), 1'b0, 2'd3},
    // R8 invalid at level 1
    '{64'h0000_0000_0001_0000, ROOT, mk(48'h0000_0050_0000, 2'b00, 1, 3'd1, 2'd1, 2'd1), 64'h0, 64'h0, 1'b1, 2'd1},
    // R8 invalid (0b10) at level 2
    '{64'h0000_0400_2000_0000, ROOT, mk(48'h0000_0030_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0),
      mk(48'h0000_4000_0000, 2'b10, 1, 3'd2, 2'd1, 2'd3), 64'h0, 1'b1, 2'd2},
    // R10 block encoding at level 3
    '{64'h0000_0000_0003_4567, ROOT, mk(48'h0000_0010_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0),
      mk(48'h0000_0020_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0), mk(48'h0000_1234_0000, 2'b01, 1, 3'd4, 2'd1, 2'd3), 1'b1, 2'd3},
    // R9 access flag clear on level-1 block
    '{64'h0000_8000_0000_0000, ROOT, mk(48'h4000_0000_0000, 2'b01, 0, 3'd2, 2'd1, 2'd3), 64'h0, 64'h0, 1'b1, 2'd1},
    // R9 access flag clear on level-3 page
    '{64'h0000_0000_0005_0000, ROOT, mk(48'h0000_0010_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0),
      mk(48'h0000_0020_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0), mk(48'h0000_7777_0000, 2'b11, 0, 3'd6, 2'd1, 2'd3), 1'b1, 2'd3},
    // R11 top bit set
    '{64'h8000_0000_0000_0000, ROOT, 64'h0, 64'h0, 64'h0, 1'b1, 2'd0},
    // R11 bit 48 set
    '{64'h0001_0000_0000_0000, ROOT, 64'h0, 64'h0, 64'h0, 1'b1, 2'd0},
    // R9 access flag clear on level-2 block
    '{64'h0000_0000_4000_0000, ROOT, mk(48'h0000_0060_0000, 2'b11, 1, 3'd0, 2'd0, 2'd0),
      mk(48'h0000_2000_0000, 2'b01, 0, 3'd1, 2'd1, 2'd1), 64'h0, 1'b1, 2'd2},
    // R3 table pointer with clear access flag still walks
    '{64'h0000_0000_7654_3210, ROOT, mk(48'h0000_0070_0000, 2'b11, 0, 3'd0, 2'd0, 2'd0),
      mk(48'h0000_6000_0000, 2'b01, 1, 3'd2, 2'd3, 2'd2), 64'h0, 1'b0, 2'd2}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_pa(input logic [63:0] va, input logic [63:0] d, input logic [1:0] lvl);
    case (lvl)
      2'd1:    return {d[47:42], va[41:0]};
      2'd2:    return {d[47:29], va[28:0]};
      default: return {d[47:16], va[15:0]};
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input bit poke);
    logic [63:0] descs [3];
    logic [47:0] exp_addr;
    int nreq = 0;
    int ndone = 0;
    descs[0] = v.d1; descs[1] = v.d2; descs[2] = v.d3;
    @(negedge clk_i);
    start_i = 1'b1; va_i = v.va; root_base_i = v.root;
    @(negedge clk_i);
    start_i = 1'b0;
    exp_addr = v.root + {39'b0, v.va[47:42], 3'b0};
    for (int c = 0; c < 60 && ndone == 0; c++) begin
      if (mem_req_o) begin
        // R2 R3 fetch address and one read per level
        chk(nreq < 3 && mem_addr_o == exp_addr, "R2/R3 fetch address", {16'h0, mem_addr_o}, {16'h0, exp_addr});
        chk(!ready_o, "R12 busy during walk", {63'h0, ready_o}, 64'h0);
        if (nreq < 2)
          exp_addr = {descs[nreq][47:16], (nreq == 0) ? v.va[41:29] : v.va[28:16], 3'b0};
        mem_rdata_i = descs[nreq < 3 ? nreq : 2];
        nreq++;
        repeat (2) @(negedge clk_i);
        if (poke) begin start_i = 1'b1; va_i = 64'h0000_0000_0000_0001; root_base_i = 48'h0; end
        mem_rvalid_i = 1'b1;
        @(negedge clk_i);
        mem_rvalid_i = 1'b0; start_i = 1'b0;
      end else if (done_o) begin
        ndone++;
        chk(fault_o == v.flt, "R8/R9/R10/R11 fault flag", {63'h0, fault_o}, {63'h0, v.flt});
        chk(fault_level_o == v.lvl || !v.flt, "R8/R9/R10/R11 fault level", {62'h0, fault_level_o}, {62'h0, v.lvl});
        chk(nreq == int'(v.lvl), "R12 read count", 64'(nreq), 64'(v.lvl));
        if (!v.flt) begin
          chk(pa_o == exp_pa(v.va, descs[v.lvl-1], v.lvl), "R4/R5/R6 physical address",
              {16'h0, pa_o}, {16'h0, exp_pa(v.va, descs[v.lvl-1], v.lvl)});
          chk({attr_idx_o, perm_o, share_o} == {descs[v.lvl-1][4:2], descs[v.lvl-1][7:6], descs[v.lvl-1][9:8]},
              "R7 attribute fields", {57'h0, attr_idx_o, perm_o, share_o},
              {57'h0, descs[v.lvl-1][4:2], descs[v.lvl-1][7:6], descs[v.lvl-1][9:8]});
        end else begin
          chk(pa_o == '0 && attr_idx_o == '0 && perm_o == '0 && share_o == '0, "R8 zero result on fault",
              {16'h0, pa_o}, 64'h0);
        end
        @(negedge clk_i);
        chk(ready_o && !done_o, "R12 ready after single done", {62'h0, ready_o, done_o}, 64'h2);
      end else begin
        @(negedge clk_i);
      end
    end
    chk(ndone == 1, "R12 done seen", 64'(ndone), 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ready_o && !done_o && !mem_req_o, "R1 reset outputs", {61'h0, ready_o, done_o, mem_req_o}, 64'h4);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o && !done_o && !mem_req_o, "R1 after reset release", {61'h0, ready_o, done_o, mem_req_o}, 64'h4);
    for (int i = 0; i < 12; i++) run_vec(VECS[i], 1'b0);
    // R12 start while busy is ignored
    run_vec(VECS[2], 1'b1);
    run_vec(VECS[1], 1'b1);
    // back-to-back after a range fault
    run_vec(VECS[8], 1'b0);
    run_vec(VECS[0], 1'b0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule